// File: doc/BRIEF.md
# Transmit Character Source Sequencer

Each character period, this block decides what the transmitter sends next. There are three possible sources: the next character held in the transmit FIFO, a SYNC fill character, or one character of a built-in pseudo-random self-test pattern. When it takes a character from the FIFO it pulses the FIFO read strobe. It then registers one character, a command flag and a source code, and presents them to the downstream encoder together with a one-cycle valid pulse.

The sources are ranked in a fixed order. Self-test comes first, then halt, then an empty source (which sends SYNC), and FIFO data comes last. When the FIFO is bypassed, a one-entry holding register takes the host's characters directly. A busy flag tells the host when that register cannot take another character. When the reference clock runs at twice the character rate, the block makes one character slot every second clock. In that mode the busy flag in bypass also toggles once per character period, so the host has a rate reference.

Top module: `tx_src_seq`

## Requirements
- R1: While rst_ni is low, and after it is released, char_valid_o=0, fifo_rd_o=0, busy_o=0, src_o=1 (SYNC), char_o=0 and cmd_o=0 until the first character slot.
- R2: With half_rate_i=0 every clock is a character slot. With half_rate_i=1 a slot occurs every second clock, starting on the second clock after half_rate_i rises. char_valid_o pulses high in the cycle after each slot.
- R3: In FIFO mode (bypass_i=0), when not in self-test, with halt_ni=1 and fifo_empty_i=0 in a slot, fifo_rd_o is high in that cycle. In the next cycle char_o and cmd_o carry fifo_data_i and fifo_cmd_i, and src_o=0 (DATA).
- R4: In a slot where the selected source has no character, the output is char_o=SYNC_CHAR (default 8'hBC), cmd_o=1 and src_o=1.
- R5: In a slot where halt_ni=0, the output is SYNC (as in R4) and no FIFO read takes place. Characters written to the FIFO during the halt are sent afterwards, in order.
- R6: About two clocks after bist_en_ni goes low (two-flop synchroniser), every slot emits a test character with src_o=2 and cmd_o=0. char_o is the low 8 bits of a 9-bit LFSR. The LFSR starts at 9'h1FF and then steps as s <= {s[7:0], s[8]^s[4]}. The sequence repeats every 511 characters.
- R7: Self-test overrides halt_ni, bypass_i and source availability, and no FIFO read or bypass consume happens while it is active.
- R8: When bist_en_ni returns high, normal sourcing (R3 to R5) resumes after the synchroniser delay.
- R9: In bypass mode (bypass_i=1), fifo_rd_o stays 0. A byp_wr_i write is accepted only while the holding register is empty, and a write made while it is full is ignored. busy_o is high while the register holds a character. The held character is sent, as src_o=0, in the next slot that is not halted and not in self-test.
- R10: In bypass mode with half_rate_i=1, busy_o is also high on the non-slot clock of each character period, so it toggles once per period while the register is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bist_en_ni | input | 1 | Self-test enable, active low, asynchronous |
| halt_ni | input | 1 | Halt, active low: send SYNC |
| bypass_i | input | 1 | 1 = FIFO bypassed, use holding register |
| half_rate_i | input | 1 | 1 = reference clock at twice the character rate |
| fifo_empty_i | input | 1 | Transmit FIFO empty |
| fifo_data_i | input | CHAR_W | FIFO head character |
| fifo_cmd_i | input | 1 | FIFO head command flag |
| fifo_rd_o | output | 1 | FIFO read strobe |
| byp_wr_i | input | 1 | Bypass write strobe |
| byp_data_i | input | CHAR_W | Bypass character |
| byp_cmd_i | input | 1 | Bypass command flag |
| busy_o | output | 1 | Bypass busy / character-rate toggle |
| char_valid_o | output | 1 | New character on char_o |
| char_o | output | CHAR_W | Character to encoder |
| cmd_o | output | 1 | Command flag to encoder |
| src_o | output | 2 | 0 data, 1 SYNC, 2 test |

## Verification
The assertions assume that bist_en_ni may change at any clock, while every other input is synchronous to clk_i. They also assume the FIFO head stays stable while fifo_empty_i is low and no read is taken. The bench changes all inputs only on the falling edge. It models the FIFO as a queue whose head it presents directly, and in normal bypass traffic it writes only while busy_o is low. A separate phase writes deliberately while busy_o is high, so that R9's ignored-write rule is exercised.

// File: rtl/tx_src_pkg.sv
package tx_src_pkg;
  typedef enum logic [1:0] {
    SRC_DATA = 2'd0,
    SRC_SYNC = 2'd1,
    SRC_TEST = 2'd2
  } src_e;

  localparam int LFSR_W = 9;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[8] ^ s[4]};
  endfunction
endpackage

// File: rtl/tx_src_rate.sv
module tx_src_rate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic half_rate_i,
  output logic phase_o,
  output logic slot_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= half_rate_i & ~phase_q;
  end

  assign phase_o = phase_q;
  assign slot_o  = ~half_rate_i | phase_q;
endmodule

// File: rtl/tx_src_prbs.sv
module tx_src_prbs
  import tx_src_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 9'h1FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bist_en_ni,
  input  logic              slot_i,
  output logic              act_o,
  output logic [LFSR_W-1:0] pat_o
);
  logic s1_q, s2_q;
  logic [LFSR_W-1:0] lfsr_q;

  // two-flop synchroniser, reset to inactive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= bist_en_ni;
      s2_q <= s1_q;
    end
  end

  assign act_o = ~s2_q;

  // held at seed while idle so the first test character is the seed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lfsr_q <= SEED;
    else if (!act_o) lfsr_q <= SEED;
    else if (slot_i) lfsr_q <= lfsr_step(lfsr_q);
  end

  assign pat_o = lfsr_q;
endmodule

// File: rtl/tx_src_hold.sv
module tx_src_hold #(
  parameter int CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bypass_i,
  input  logic              wr_i,
  input  logic [CHAR_W-1:0] data_i,
  input  logic              cmd_i,
  input  logic              consume_i,
  output logic              full_o,
  output logic [CHAR_W-1:0] data_o,
  output logic              cmd_o
);
  logic              full_q;
  logic [CHAR_W-1:0] data_q;
  logic              cmd_q;
  logic              accept;

  assign accept = bypass_i & wr_i & ~full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
      cmd_q  <= 1'b0;
    end else if (!bypass_i) begin
      full_q <= 1'b0;
    end else if (accept) begin
      full_q <= 1'b1;
      data_q <= data_i;
      cmd_q  <= cmd_i;
    end else if (consume_i) begin
      full_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
  assign cmd_o  = cmd_q;
endmodule

// File: rtl/tx_src_seq.sv
module tx_src_seq
  import tx_src_pkg::*;
#(
  parameter int                CHAR_W    = 8,
  parameter logic [CHAR_W-1:0] SYNC_CHAR = 8'hBC,
  parameter logic [8:0]        SEED      = 9'h1FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bist_en_ni,
  input  logic              halt_ni,
  input  logic              bypass_i,
  input  logic              half_rate_i,
  input  logic              fifo_empty_i,
  input  logic [CHAR_W-1:0] fifo_data_i,
  input  logic              fifo_cmd_i,
  output logic              fifo_rd_o,
  input  logic              byp_wr_i,
  input  logic [CHAR_W-1:0] byp_data_i,
  input  logic              byp_cmd_i,
  output logic              busy_o,
  output logic              char_valid_o,
  output logic [CHAR_W-1:0] char_o,
  output logic              cmd_o,
  output logic [1:0]        src_o
);
  localparam int PAT_W = (CHAR_W < LFSR_W) ? CHAR_W : LFSR_W;

  logic              phase, slot, test_act;
  logic [LFSR_W-1:0] pat;
  logic              hold_full, hold_cmd;
  logic [CHAR_W-1:0] hold_data;
  logic              avail;
  src_e              sel;
  logic [CHAR_W-1:0] nxt_char;
  logic              nxt_cmd;
  logic              hold_consume;

  logic              valid_q, cmd_q;
  logic [CHAR_W-1:0] char_q;
  src_e              src_q;

  tx_src_rate u_rate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .half_rate_i(half_rate_i),
    .phase_o    (phase),
    .slot_o     (slot)
  );

  tx_src_prbs #(.SEED(SEED)) u_prbs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bist_en_ni(bist_en_ni),
    .slot_i    (slot),
    .act_o     (test_act),
    .pat_o     (pat)
  );

  tx_src_hold #(.CHAR_W(CHAR_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bypass_i (bypass_i),
    .wr_i     (byp_wr_i),
    .data_i   (byp_data_i),
    .cmd_i    (byp_cmd_i),
    .consume_i(hold_consume),
    .full_o   (hold_full),
    .data_o   (hold_data),
    .cmd_o    (hold_cmd)
  );

  assign avail = bypass_i ? hold_full : ~fifo_empty_i;

  // priority: self-test, halt, empty source, data
  always_comb begin
    nxt_char = SYNC_CHAR;
    nxt_cmd  = 1'b1;
    if (test_act) begin
      sel      = SRC_TEST;
      nxt_char = '0;
      nxt_char[PAT_W-1:0] = pat[PAT_W-1:0];
      nxt_cmd  = 1'b0;
    end else if (!halt_ni || !avail) begin
      sel = SRC_SYNC;
    end else begin
      sel      = SRC_DATA;
      nxt_char = bypass_i ? hold_data : fifo_data_i;
      nxt_cmd  = bypass_i ? hold_cmd  : fifo_cmd_i;
    end
  end

  assign fifo_rd_o    = slot & ~bypass_i & (sel == SRC_DATA);
  assign hold_consume = slot &  bypass_i & (sel == SRC_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      char_q  <= '0;
      cmd_q   <= 1'b0;
      src_q   <= SRC_SYNC;
    end else begin
      valid_q <= slot;
      if (slot) begin
        char_q <= nxt_char;
        cmd_q  <= nxt_cmd;
        src_q  <= sel;
      end
    end
  end

  assign busy_o       = bypass_i & (hold_full | (half_rate_i & ~phase));
  assign char_valid_o = valid_q;
  assign char_o       = char_q;
  assign cmd_o        = cmd_q;
  assign src_o        = src_q;
endmodule

// File: rtl/tx_src_seq_chk.sv
module tx_src_seq_chk #(
  parameter int                CHAR_W    = 8,
  parameter logic [CHAR_W-1:0] SYNC_CHAR = 8'hBC
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              halt_ni,
  input logic              bypass_i,
  input logic              half_rate_i,
  input logic              fifo_empty_i,
  input logic [CHAR_W-1:0] fifo_data_i,
  input logic              fifo_cmd_i,
  input logic              fifo_rd_o,
  input logic              char_valid_o,
  input logic [CHAR_W-1:0] char_o,
  input logic              cmd_o,
  input logic [1:0]        src_o,
  input logic              slot,
  input logic              test_act,
  input logic [8:0]        pat
);
  assert_rd_delivers_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |=> char_valid_o && src_o == 2'd0 &&
                  char_o == $past(fifo_data_i) && cmd_o == $past(fifo_cmd_i));

  assert_empty_sync_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot && !test_act && halt_ni && !bypass_i && fifo_empty_i) |=>
      src_o == 2'd1 && char_o == SYNC_CHAR && cmd_o);

  assert_halt_no_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot && !halt_ni) |=> src_o != 2'd0);

  assert_half_rate_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_rate_i && char_valid_o) |=> !char_valid_o);

  assert_lfsr_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_act |-> pat != 9'd0);

  assert_test_no_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_act |-> !fifo_rd_o);

  assert_bypass_no_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |-> !fifo_rd_o);
endmodule

bind tx_src_seq tx_src_seq_chk #(.CHAR_W(CHAR_W), .SYNC_CHAR(SYNC_CHAR)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .halt_ni     (halt_ni),
  .bypass_i    (bypass_i),
  .half_rate_i (half_rate_i),
  .fifo_empty_i(fifo_empty_i),
  .fifo_data_i (fifo_data_i),
  .fifo_cmd_i  (fifo_cmd_i),
  .fifo_rd_o   (fifo_rd_o),
  .char_valid_o(char_valid_o),
  .char_o      (char_o),
  .cmd_o       (cmd_o),
  .src_o       (src_o),
  .slot        (slot),
  .test_act    (test_act),
  .pat         (pat)
);

// File: tb/tx_src_seq_test.sv
module tx_src_seq_test;
  localparam int         CW   = 8;
  localparam logic [7:0] SYNC = 8'hBC;
  localparam int         SEED = 9'h1FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bist_en_n = 1'b1, halt_n = 1'b1, bypass = 1'b0, half = 1'b0;
  logic fifo_empty = 1'b1, fifo_cmd = 1'b0, byp_wr = 1'b0, byp_cmd = 1'b0;
  logic [CW-1:0] fifo_data = '0, byp_data = '0;
  logic fifo_rd, busy, valid, cmd;
  logic [CW-1:0] chr;
  logic [1:0] src;

  always #4 clk = ~clk;

  tx_src_seq #(.CHAR_W(CW), .SYNC_CHAR(SYNC), .SEED(9'h1FF)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bist_en_ni(bist_en_n), .halt_ni(halt_n),
    .bypass_i(bypass), .half_rate_i(half), .fifo_empty_i(fifo_empty),
    .fifo_data_i(fifo_data), .fifo_cmd_i(fifo_cmd), .fifo_rd_o(fifo_rd),
    .byp_wr_i(byp_wr), .byp_data_i(byp_data), .byp_cmd_i(byp_cmd),
    .busy_o(busy), .char_valid_o(valid), .char_o(chr), .cmd_o(cmd), .src_o(src)
  );

  int n_chk = 0, n_fail = 0;
  // behavioural model state
  bit m_phase = 0, m_s1 = 1, m_s2 = 1, m_valid = 0, m_cmd = 0;
  int m_lfsr = SEED, m_char = 0, m_src = 1;
  logic [8:0] fq[$];
  logic [8:0] bq[$];
  // stimulus control
  bit push_en = 0, byp_auto = 0, byp_force = 0;
  int push_cnt = 0, byp_cnt = 0, data_seen = 0;
  int tst_n = 0;
  logic [7:0] tst_first;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_busy();
    return bypass && (bq.size() > 0 || (half && !m_phase));
  endfunction

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      bit slot, act, rd, full_pre;
      string tg;
      // drive at negedge
      if (push_en && fq.size() < 8) begin
        fq.push_back({push_cnt[0], 8'(push_cnt + 8'h10)});
        push_cnt++;
      end
      fifo_empty = (fq.size() == 0);
      {fifo_cmd, fifo_data} = fifo_empty ? 9'h0 : fq[0];
      byp_wr   = byp_force || (byp_auto && !exp_busy());
      byp_data = 8'(byp_cnt + 8'h80);
      byp_cmd  = byp_cnt[1];
      #1;
      slot = !half || m_phase;
      act  = !m_s2;
      rd   = slot && !bypass && !act && halt_n && fq.size() > 0;
      // compare
      chk("R2", "char_valid", valid, m_valid);
      tg = (m_src == 2) ? "R6" : (m_src == 0) ? "R3" : "R4";
      chk(tg, "src", src, m_src);
      chk(tg, "char", chr, m_char);
      chk(tg, "cmd", cmd, m_cmd);
      chk(act ? "R7" : (bypass ? "R9" : "R3"), "fifo_rd", fifo_rd, rd);
      chk((bypass && half) ? "R10" : "R9", "busy", busy, exp_busy());
      if (valid && src == 2) begin
        if (tst_n == 0) tst_first = chr;
        if (tst_n == 511) chk("R6", "period 511", chr, tst_first);
        tst_n++;
      end
      if (valid && src == 0) data_seen++;
      @(posedge clk);
      // model update
      full_pre = bq.size() > 0;
      if (slot) begin
        m_valid = 1;
        if (act) begin
          m_src = 2; m_char = m_lfsr & 8'hFF; m_cmd = 0;
        end else if (!halt_n || !(bypass ? full_pre : fq.size() > 0)) begin
          m_src = 1; m_char = SYNC; m_cmd = 1;
        end else begin
          logic [8:0] w;
          w = bypass ? bq.pop_front() : fq.pop_front();
          m_src = 0; m_char = w[7:0]; m_cmd = w[8];
        end
      end else m_valid = 0;
      if (!bypass) bq.delete();
      else if (byp_wr && !full_pre) begin
        bq.push_back({byp_cmd, byp_data});
        byp_cnt++;
      end else if (byp_wr) byp_cnt++;
      if (!act) m_lfsr = SEED;
      else if (slot) m_lfsr = ((m_lfsr << 1) & 9'h1FF) | (((m_lfsr >> 8) ^ (m_lfsr >> 4)) & 1);
      m_phase = half && !m_phase;
      m_s2 = m_s1;
      m_s1 = bist_en_n;
      @(negedge clk);
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "valid in reset", valid, 0);
    chk("R1", "rd in reset", fifo_rd, 0);
    chk("R1", "busy in reset", busy, 0);
    chk("R1", "src in reset", src, 1);
    chk("R1", "char in reset", chr, 0);
    rst_n = 1'b1;
    // FIFO mode, full rate
    push_en = 1; tick(20);
    push_en = 0; tick(12);
    // halt while host keeps loading
    halt_n = 0; push_en = 1; tick(10);
    push_en = 0; tick(2);
    halt_n = 1; tick(16);
    // self-test overrides halt and bypass
    bist_en_n = 0; push_en = 1; tick(100);
    halt_n = 0; tick(50);
    bypass = 1; byp_auto = 1; tick(50);
    bypass = 0; byp_auto = 0; halt_n = 1; tick(340);
    chk("R6", "test characters seen", (tst_n > 511) ? 1 : 0, 1);
    // release self-test
    bist_en_n = 1; data_seen = 0; tick(20);
    chk("R8", "data resumes after test", (data_seen > 0) ? 1 : 0, 1);
    // half-rate FIFO mode
    half = 1; tick(30);
    push_en = 0; tick(20);
    // bypass, full rate
    half = 0; bypass = 1; byp_auto = 1; tick(30);
    byp_auto = 0; byp_force = 1; tick(12);
    byp_force = 0; halt_n = 0; byp_auto = 1; tick(8);
    halt_n = 1; tick(10);
    // bypass, half rate: busy toggles while empty
    half = 1; byp_auto = 0; tick(12);
    byp_auto = 1; tick(24);
    byp_force = 1; tick(10);
    byp_force = 0; tick(6);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule